// File: doc/BRIEF.md
# Audio Codec Link Frame Serializer

This block drives the controller side of a serial audio codec link. One bit-clock period carries one bit. The block repeats a 256-bit frame that is made of a 16-bit tag slot and twelve 20-bit slots. During the frame it shifts its own output frame out on one serial line, MSB first, and in the same bit periods it shifts the codec's input frame in on another line. A frame-sync line marks the tag slot, so the codec can find the start of each frame. At the default 12.288 MHz bit clock the frame rate is 48 kHz.

Playback samples are 18-bit signed PCM values. The block packs them into the upper 18 bits of the left and right audio slots. It also copies two 20-bit command words unchanged into the two slots that come before the audio. In the other direction it takes the two status words and the two capture samples out of the frame it receives. A ready pulse, one bit period long and issued once per frame, marks the single moment when the next frame's playback data is taken and the received data is updated.

Top module: `alink_frame_serializer`

## Requirements
- R1: The frame repeats every 256 bit periods. `frameSync` is high for the first 16 bit periods of each frame (the tag slot) and low for the other 240.
- R2: `readyPulse` is high for exactly one bit period per frame, the last bit period of the frame. It is low while reset is asserted.
- R3: `serialOut` changes only after a rising edge of `bitClk` and sends each frame MSB first. `serialIn` is sampled on the falling edge of `bitClk`.
- R4: The tag slot is sent as 16'hF800: the first bit (bit 15) is the frame-valid flag, bits 14..11 flag slots 1 to 4 as valid, and bits 10..0 are zero. Slots 5 to 12 are sent as all zeros.
- R5: Slot 3 (frame bits 56..75, counted from 0 at the first bit) carries `{txLeft, 2'b00}`. Slot 4 (bits 76..95) carries `{txRight, 2'b00}`. The sample values are taken at the rising edge that ends a bit period in which `readyPulse` is high, and they are sent in the frame that begins at that edge.
- R6: Slot 1 (bits 16..35) carries `txCmdAddr` and slot 2 (bits 36..55) carries `txCmdData`. Both are taken at the same edge as the samples.
- R7: At the rising edge that ends a ready period, `rxLeft` and `rxRight` load the upper 18 bits of slots 3 and 4 of the frame just received, and `rxStatusAddr` and `rxStatusData` load slots 1 and 2. The low 2 bits of slots 3 and 4 have no effect. Between two such edges all four stay unchanged.
- R8: While reset is asserted, `frameSync`, `serialOut`, `readyPulse` and all received outputs are 0. The first frame after reset carries the tag and all-zero slots 1 to 12, whatever the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txLeft | input | 18 | Left playback sample |
| txRight | input | 18 | Right playback sample |
| txCmdAddr | input | 20 | Word sent in slot 1 |
| txCmdData | input | 20 | Word sent in slot 2 |
| serialIn | input | 1 | Serial input frame from the codec |
| serialOut | output | 1 | Serial output frame to the codec |
| frameSync | output | 1 | High during the tag slot |
| readyPulse | output | 1 | High during the last bit period of each frame |
| rxLeft | output | 18 | Left capture sample |
| rxRight | output | 18 | Right capture sample |
| rxStatusAddr | output | 20 | Received slot 1 word |
| rxStatusData | output | 20 | Received slot 2 word |

## Verification
The bench builds the block with its default parameters: a 16-bit tag slot, 20-bit data slots, 13 slots and 18-bit samples. This gives the full 256-bit frame, so every bit period of six whole frames is compared against a behavioural frame model. This covers the tag bits, each slot boundary, the two pad bits under each sample, and the turn from one frame to the next. The sample values include the most negative and most positive 18-bit codes. One received frame has all bits set, so any leak from pad bits or later slots into the captured values would show.

// File: rtl/alink_pkg.sv
package alink_pkg;
  typedef struct packed {
    logic loadFrame;
    logic takeSamples;
    logic rxShiftEn;
  } alink_strobe_t;
endpackage

// File: rtl/alink_ctrl.sv
module alink_ctrl #(
  parameter int SLOT0_BITS  = 16,
  parameter int SLOT_BITS   = 20,
  parameter int NUM_SLOTS   = 13,
  parameter int SAMPLE_BITS = 18
) (
  input  logic                    bitClk,
  input  logic                    rstN,
  output alink_pkg::alink_strobe_t strobe,
  output logic                    frameSync,
  output logic                    readyPulse
);
  localparam int FRAME_BITS = SLOT0_BITS + (NUM_SLOTS - 1) * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int LAST       = FRAME_BITS - 1;
  localparam int CMD_START  = SLOT0_BITS;
  localparam int LEFT_START = SLOT0_BITS + 2 * SLOT_BITS;
  localparam int RGHT_START = LEFT_START + SLOT_BITS;

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] cntNext;
  logic             readyReg;

  assign cntNext = (bitCnt == CNT_W'(LAST)) ? '0 : bitCnt + 1'b1;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= CNT_W'(LAST);
      readyReg <= 1'b0;
    end else begin
      bitCnt   <= cntNext;
      readyReg <= (cntNext == CNT_W'(LAST));
    end
  end

  assign frameSync  = (bitCnt < CNT_W'(SLOT0_BITS));
  assign readyPulse = readyReg;

  // Only bits that end up in an output are shifted in: both command slots
  // and the upper SAMPLE_BITS of each audio slot.
  always_comb begin
    strobe.loadFrame   = (bitCnt == CNT_W'(LAST));
    strobe.takeSamples = readyReg;
    strobe.rxShiftEn   =
        ((bitCnt >= CNT_W'(CMD_START))  && (bitCnt < CNT_W'(LEFT_START))) ||
        ((bitCnt >= CNT_W'(LEFT_START)) && (bitCnt < CNT_W'(LEFT_START + SAMPLE_BITS))) ||
        ((bitCnt >= CNT_W'(RGHT_START)) && (bitCnt < CNT_W'(RGHT_START + SAMPLE_BITS)));
  end

  assert_ready_single_R2: assert property (@(posedge bitClk) disable iff (!rstN)
    readyPulse |=> !readyPulse);

  assert_sync_after_ready_R1: assert property (@(posedge bitClk) disable iff (!rstN)
    readyPulse |=> frameSync);

  assert_sync_length_R1: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(frameSync) |-> (bitCnt == CNT_W'(SLOT0_BITS)));
endmodule

// File: rtl/alink_datapath.sv
module alink_datapath #(
  parameter int SLOT0_BITS  = 16,
  parameter int SLOT_BITS   = 20,
  parameter int NUM_SLOTS   = 13,
  parameter int SAMPLE_BITS = 18
) (
  input  logic                    bitClk,
  input  logic                    rstN,
  input  alink_pkg::alink_strobe_t strobe,
  input  logic [SAMPLE_BITS-1:0]  txLeft,
  input  logic [SAMPLE_BITS-1:0]  txRight,
  input  logic [SLOT_BITS-1:0]    txCmdAddr,
  input  logic [SLOT_BITS-1:0]    txCmdData,
  input  logic                    serialIn,
  output logic                    serialOut,
  output logic [SAMPLE_BITS-1:0]  rxLeft,
  output logic [SAMPLE_BITS-1:0]  rxRight,
  output logic [SLOT_BITS-1:0]    rxStatusAddr,
  output logic [SLOT_BITS-1:0]    rxStatusData
);
  localparam int FRAME_BITS = SLOT0_BITS + (NUM_SLOTS - 1) * SLOT_BITS;
  localparam int PAD_BITS   = SLOT_BITS - SAMPLE_BITS;
  localparam int RX_BITS    = 2 * SLOT_BITS + 2 * SAMPLE_BITS;
  localparam logic [SLOT0_BITS-1:0] TAG_WORD = {5'b11111, {(SLOT0_BITS - 5){1'b0}}};

  function automatic int slotTop(int s);
    return FRAME_BITS - 1 - SLOT0_BITS - (s - 1) * SLOT_BITS;
  endfunction

  localparam int TOP_ADDR = slotTop(1);
  localparam int TOP_DATA = slotTop(2);
  localparam int TOP_LEFT = slotTop(3);
  localparam int TOP_RGHT = slotTop(4);

  logic [FRAME_BITS-1:0] nextFrame;
  logic [FRAME_BITS-1:0] txShift;
  logic                  rxBit;
  logic [RX_BITS-1:0]    rxShift;

  always_comb begin
    nextFrame = '0;
    nextFrame[FRAME_BITS-1 -: SLOT0_BITS] = TAG_WORD;
    if (strobe.takeSamples) begin
      nextFrame[TOP_ADDR -: SLOT_BITS] = txCmdAddr;
      nextFrame[TOP_DATA -: SLOT_BITS] = txCmdData;
      nextFrame[TOP_LEFT -: SLOT_BITS] = {txLeft,  {PAD_BITS{1'b0}}};
      nextFrame[TOP_RGHT -: SLOT_BITS] = {txRight, {PAD_BITS{1'b0}}};
    end
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.loadFrame) begin
      txShift <= nextFrame;
    end else begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign serialOut = txShift[FRAME_BITS-1];

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) rxBit <= 1'b0;
    else       rxBit <= serialIn;
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobe.rxShiftEn) begin
      rxShift <= {rxShift[RX_BITS-2:0], rxBit};
    end
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      rxStatusAddr <= '0;
      rxStatusData <= '0;
      rxLeft       <= '0;
      rxRight      <= '0;
    end else if (strobe.takeSamples) begin
      rxStatusAddr <= rxShift[RX_BITS-1 -: SLOT_BITS];
      rxStatusData <= rxShift[RX_BITS-1-SLOT_BITS -: SLOT_BITS];
      rxLeft       <= rxShift[2*SAMPLE_BITS-1 -: SAMPLE_BITS];
      rxRight      <= rxShift[SAMPLE_BITS-1:0];
    end
  end

  assert_rx_hold_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    !strobe.takeSamples |=> ($stable(rxLeft) && $stable(rxRight) &&
                             $stable(rxStatusAddr) && $stable(rxStatusData)));

  assert_tag_first_R4: assert property (@(posedge bitClk) disable iff (!rstN)
    strobe.loadFrame |=> serialOut);
endmodule

// File: rtl/alink_frame_serializer.sv
module alink_frame_serializer #(
  parameter int SLOT0_BITS  = 16,
  parameter int SLOT_BITS   = 20,
  parameter int NUM_SLOTS   = 13,
  parameter int SAMPLE_BITS = 18
) (
  input  logic                   bitClk,
  input  logic                   rstN,
  input  logic [SAMPLE_BITS-1:0] txLeft,
  input  logic [SAMPLE_BITS-1:0] txRight,
  input  logic [SLOT_BITS-1:0]   txCmdAddr,
  input  logic [SLOT_BITS-1:0]   txCmdData,
  input  logic                   serialIn,
  output logic                   serialOut,
  output logic                   frameSync,
  output logic                   readyPulse,
  output logic [SAMPLE_BITS-1:0] rxLeft,
  output logic [SAMPLE_BITS-1:0] rxRight,
  output logic [SLOT_BITS-1:0]   rxStatusAddr,
  output logic [SLOT_BITS-1:0]   rxStatusData
);
  alink_pkg::alink_strobe_t strobe;

  alink_ctrl #(
    .SLOT0_BITS(SLOT0_BITS), .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS), .SAMPLE_BITS(SAMPLE_BITS)
  ) uCtrl (
    .bitClk(bitClk), .rstN(rstN), .strobe(strobe),
    .frameSync(frameSync), .readyPulse(readyPulse)
  );

  alink_datapath #(
    .SLOT0_BITS(SLOT0_BITS), .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS), .SAMPLE_BITS(SAMPLE_BITS)
  ) uData (
    .bitClk(bitClk), .rstN(rstN), .strobe(strobe),
    .txLeft(txLeft), .txRight(txRight),
    .txCmdAddr(txCmdAddr), .txCmdData(txCmdData),
    .serialIn(serialIn), .serialOut(serialOut),
    .rxLeft(rxLeft), .rxRight(rxRight),
    .rxStatusAddr(rxStatusAddr), .rxStatusData(rxStatusData)
  );
endmodule

// File: tb/sim_alink_frame_serializer.sv
module sim_alink_frame_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int NFRAMES    = 6;

  logic        bitClk = 1'b0;
  logic        rstN   = 1'b0;
  logic [17:0] txLeft = '0, txRight = '0;
  logic [19:0] txCmdAddr = '0, txCmdData = '0;
  logic        serialIn = 1'b0;
  logic        serialOut, frameSync, readyPulse;
  logic [17:0] rxLeft, rxRight;
  logic [19:0] rxStatusAddr, rxStatusData;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  alink_frame_serializer u0 (
    .bitClk(bitClk), .rstN(rstN), .txLeft(txLeft), .txRight(txRight),
    .txCmdAddr(txCmdAddr), .txCmdData(txCmdData), .serialIn(serialIn),
    .serialOut(serialOut), .frameSync(frameSync), .readyPulse(readyPulse),
    .rxLeft(rxLeft), .rxRight(rxRight),
    .rxStatusAddr(rxStatusAddr), .rxStatusData(rxStatusData)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [255:0] buildFrame(logic [17:0] l, logic [17:0] r,
                                              logic [19:0] a, logic [19:0] d);
    logic [255:0] f = '0;
    f[255:240] = 16'hF800;
    f[239:220] = a;
    f[219:200] = d;
    f[199:180] = {l, 2'b00};
    f[179:160] = {r, 2'b00};
    return f;
  endfunction

  function automatic logic [255:0] randFrame(int idx);
    logic [255:0] f;
    for (int w = 0; w < 8; w++) f[w*32 +: 32] = $urandom;
    if (idx == 3) f = '1;
    return f;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pos = 255;
    int frameIdx = 0;
    logic readyHeld = 1'b0;
    logic [255:0] txExp = '0;
    logic [255:0] rxCur;
    logic [17:0] expL = '0, expR = '0;
    logic [19:0] expA = '0, expD = '0;
    string txReq;

    rxCur = randFrame(0);
    // Inputs non-zero during reset: the first frame must still be empty (R8)
    txLeft = 18'h15555; txRight = 18'h0AAAA; txCmdAddr = 20'h12345; txCmdData = 20'hABCDE;
    #(2*CLK_PERIOD + 3);
    check("R8", "frameSync in reset", frameSync, 0);
    check("R8", "serialOut in reset", serialOut, 0);
    check("R8", "readyPulse in reset", readyPulse, 0);
    check("R8", "rxLeft in reset", rxLeft, 0);
    check("R8", "rxStatusAddr in reset", rxStatusAddr, 0);
    rstN = 1'b1;

    for (int cyc = 0; cyc < NFRAMES * 256; cyc++) begin
      @(posedge bitClk);
      if (pos == 255) begin
        if (readyHeld) begin
          expA = rxCur[239:220]; expD = rxCur[219:200];
          expL = rxCur[199:182]; expR = rxCur[179:162];
          txExp = buildFrame(txLeft, txRight, txCmdAddr, txCmdData);
          frameIdx++;
        end else begin
          txExp = buildFrame('0, '0, '0, '0);
        end
        pos = 0;
        rxCur = randFrame(frameIdx);
      end else begin
        pos++;
      end
      readyHeld = (pos == 255);
      #1;
      serialIn = rxCur[255 - pos];
      if (pos == 0) begin
        if (frameIdx == 2) begin
          txLeft = 18'h20000; txRight = 18'h1FFFF;   // extreme codes (R5)
        end else begin
          txLeft = 18'($urandom); txRight = 18'($urandom);
        end
        txCmdAddr = 20'($urandom); txCmdData = 20'($urandom);
      end
      #2;
      if (pos < 16)       txReq = "R4";
      else if (pos < 56)  txReq = "R6";
      else if (pos < 96)  txReq = "R5";
      else                txReq = "R4";
      check(txReq, "serialOut bit (R3)", serialOut, txExp[255 - pos]);
      check("R1", "frameSync", frameSync, (pos < 16));
      check("R2", "readyPulse", readyPulse, readyHeld);
      check("R7", "rxLeft", rxLeft, expL);
      check("R7", "rxRight", rxRight, expR);
      check("R7", "rxStatusAddr", rxStatusAddr, expA);
      check("R7", "rxStatusData", rxStatusData, expD);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule